// File: doc/BRIEF.md
# Scatter-Gather Page DMA Engine

This block moves a host buffer between device FIFOs and host memory. The buffer is described by a table of page entries. Each entry holds a start address and a byte length. Software fills an on-chip table through a write port, sets how many entries are valid, chooses a direction and pulses start. From then on the engine walks the table by itself. It cuts every page into packets and emits them on a 64-bit packet stream. Each packet begins with one header beat.

In the toward-host direction, each packet is a write request. The header is followed by payload beats, which are popped from an external transmit FIFO. In the from-host direction, each packet is a header-only read request. The completion beats that come back are forwarded unchanged into an external receive FIFO. The engine keeps at most one read outstanding at a time.

A packet never carries more than the programmed limit for its direction, and it never crosses a 4096-byte address boundary. The engine waits rather than drop data when the FIFOs are not ready. A single interrupt pulse marks the end of the whole table.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset `busy`, `irq`, `pktValid`, `txPop` and `rxPush` are all low.
- R2: Entries are written through `descWe`/`descWrIdx`/`descWrAddr`/`descWrLen`. The table holds `DESC_DEPTH` (1024) entries. After start, the engine services entries 0 to `cfgCount-1` in index order, using the address and length stored in each entry.
- R3: Write direction (`cfgRead`=0): every packet is a header beat followed by size/8 data beats. The header beat has `pktSop`=1, bit 63 = 1, the byte size in bits 47:32, the address in bits 31:0 and zeros elsewhere. The data beats carry `txData` words in FIFO order, one pop per accepted beat, and `pktLast` is high only on the final data beat. The size is at most 8 << `cfgPayCode`, with codes above 9 meaning 4096.
- R4: Read direction (`cfgRead`=1): every packet is a single beat with `pktSop`=1, `pktLast`=1, bit 63 = 0 and the same size and address fields as R3. The size is at most 8 << `cfgReadCode` (4096 for codes of 9 and above). The next size/8 `cplData` beats appear unchanged on `rxData` with `rxPush` high, in order. The next request is issued only after all of them have arrived.
- R5: The packet size is the smallest of three values: the bytes left in the entry, the limit for the direction, and 4096 minus (address mod 4096). Successive packets start where the previous one ended. An entry whose length is not a multiple of the limit therefore ends with one shorter packet.
- R6: A write packet header is not offered until `txLevel` is at least the packet's word count.
- R7: A read request is not offered until `rxFree` is at least the packet's word count.
- R8: After the last entry is fully serviced, `irq` is high for exactly one cycle. `busy` is high from the cycle after the start pulse up to and including the `irq` cycle, and low after it.
- R9: A start pulse while `busy` is high has no effect: there is no second interrupt and no extra packet. A start with `cfgCount`=0 produces an interrupt with no packets. An entry of length 0 produces no packets.
- R10: While `pktValid` is high and `pktReady` is low, `pktValid`, `pktData`, `pktSop` and `pktLast` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| descWe | input | 1 | Table entry write strobe |
| descWrIdx | input | IDX_W | Entry index to write |
| descWrAddr | input | 32 | Entry start address (8-byte aligned) |
| descWrLen | input | LEN_W | Entry length in bytes (multiple of 8) |
| cfgCount | input | IDX_W+1 | Number of valid entries |
| cfgRead | input | 1 | 1 = read from host, 0 = write to host |
| cfgPayCode | input | 4 | Write payload limit code |
| cfgReadCode | input | 4 | Read request limit code |
| start | input | 1 | Start pulse |
| busy | output | 1 | Engine active |
| irq | output | 1 | One-cycle end-of-list pulse |
| pktValid | output | 1 | Packet beat valid |
| pktReady | input | 1 | Packet beat accepted |
| pktSop | output | 1 | Header beat marker |
| pktLast | output | 1 | Final beat of packet |
| pktData | output | 64 | Packet beat |
| txLevel | input | LVL_W | Words held in transmit FIFO |
| txData | input | 64 | Transmit FIFO head word |
| txPop | output | 1 | Transmit FIFO pop |
| rxFree | input | LVL_W | Free words in receive FIFO |
| cplValid | input | 1 | Completion beat valid |
| cplData | input | 64 | Completion beat |
| rxPush | output | 1 | Receive FIFO push |
| rxData | output | 64 | Receive FIFO write word |

## Verification
Several properties are checked by assertions on every cycle:
- every header respects its direction's size limit and the 4 KB boundary;
- a stalled beat holds steady;
- pops and pushes never meet an empty or full FIFO;
- the interrupt is a single pulse that ends busy;
- the datapath never advances by more than what is left in an entry.

Other behaviour can only be shown by the directed scenarios. These cover the exact split of pages into packets, the order and content of payload and completion words, and gating on partial FIFO levels. They also cover the handling of zero-length entries, a zero count and a repeated start.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int ADDR_W     = 32;
  localparam int PAGE_BYTES = 4096;
  localparam int PKT_W      = $clog2(PAGE_BYTES) + 1;
  localparam int WORDS_W    = PKT_W - 3;
  localparam int MAX_CODE   = 9;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_LOAD, S_SIZE, S_WAIT, S_HDR, S_DATA, S_CPL, S_NEXT, S_DONE
  } dmaState_e;

  typedef struct packed {
    logic load;
    logic size;
    logic advance;
  } dpCtl_t;

  function automatic logic [PKT_W-1:0] capBytes(input logic [3:0] code);
    if (code > 4'(MAX_CODE)) return PKT_W'(PAGE_BYTES);
    return PKT_W'(8) << code;
  endfunction
endpackage

// File: rtl/sgdma_datapath.sv
module sgdma_datapath
  import sgdma_pkg::*;
#(
  parameter int DESC_DEPTH = 1024,
  parameter int LEN_W      = 16,
  parameter int IDX_W      = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               descWe,
  input  logic [IDX_W-1:0]   descWrIdx,
  input  logic [ADDR_W-1:0]  descWrAddr,
  input  logic [LEN_W-1:0]   descWrLen,
  input  logic [IDX_W-1:0]   rdIdx,
  input  dpCtl_t             ctl,
  input  logic               isRead,
  input  logic [3:0]         payCode,
  input  logic [3:0]         readCode,
  output logic               remZero,
  output logic [WORDS_W-1:0] pktWords,
  output logic [63:0]        hdrWord
);
  logic [ADDR_W-1:0] tblAddr [DESC_DEPTH];
  logic [LEN_W-1:0]  tblLen  [DESC_DEPTH];
  logic [ADDR_W-1:0] rdAddrQ;
  logic [LEN_W-1:0]  rdLenQ;
  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  curRem;
  logic [PKT_W-1:0]  pktLen;
  logic [PKT_W-1:0]  limit, toEdge, remCap, sizeA, sizeNext;

  always_ff @(posedge clk) begin
    if (descWe) begin
      tblAddr[descWrIdx] <= descWrAddr;
      tblLen[descWrIdx]  <= descWrLen;
    end
    rdAddrQ <= tblAddr[rdIdx];
    rdLenQ  <= tblLen[rdIdx];
  end

  always_comb begin
    limit    = capBytes(isRead ? readCode : payCode);
    toEdge   = PKT_W'(PAGE_BYTES) - {1'b0, curAddr[PKT_W-2:0]};
    remCap   = (curRem > LEN_W'(PAGE_BYTES)) ? PKT_W'(PAGE_BYTES) : curRem[PKT_W-1:0];
    sizeA    = (remCap < limit) ? remCap : limit;
    sizeNext = (sizeA < toEdge) ? sizeA : toEdge;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      curRem  <= '0;
      pktLen  <= '0;
    end else begin
      if (ctl.load) begin
        curAddr <= rdAddrQ;
        curRem  <= rdLenQ;
      end
      if (ctl.size) pktLen <= sizeNext;
      if (ctl.advance) begin
        curAddr <= curAddr + ADDR_W'(pktLen);
        curRem  <= curRem - LEN_W'(pktLen);
      end
    end
  end

  assign remZero  = (curRem == '0);
  assign pktWords = pktLen[PKT_W-1:3];
  assign hdrWord  = {~isRead, 15'd0, 16'(pktLen), curAddr};

  // R5: an advance never consumes more than what is left in the entry
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |-> (LEN_W'(pktLen) <= curRem));
  // R3: every issued packet carries at least one word
  a_r3_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |-> (pktLen != '0));
endmodule

// File: rtl/sgdma_ctrl.sv
module sgdma_ctrl
  import sgdma_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int LVL_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [IDX_W:0]     cfgCount,
  input  logic               isRead,
  input  logic [LVL_W-1:0]   txLevel,
  input  logic [LVL_W-1:0]   rxFree,
  input  logic               pktReady,
  input  logic               cplValid,
  input  logic               remZero,
  input  logic [WORDS_W-1:0] pktWords,
  output dpCtl_t             ctl,
  output logic [IDX_W-1:0]   rdIdx,
  output logic               pktValid,
  output logic               pktSop,
  output logic               pktLast,
  output logic               selData,
  output logic               txPop,
  output logic               rxPush,
  output logic               busy,
  output logic               irq
);
  dmaState_e state, nextState;
  logic [IDX_W-1:0]   idx;
  logic [WORDS_W-1:0] beat;
  logic lastBeat, lastDesc, room;

  assign lastBeat = (beat == pktWords - WORDS_W'(1));
  assign lastDesc = ({1'b0, idx} == cfgCount - (IDX_W+1)'(1));
  assign room     = isRead ? (32'(rxFree) >= 32'(pktWords))
                           : (32'(txLevel) >= 32'(pktWords));

  always_comb begin
    nextState = state;
    ctl       = '0;
    pktValid  = 1'b0;
    pktSop    = 1'b0;
    pktLast   = 1'b0;
    selData   = 1'b0;
    txPop     = 1'b0;
    rxPush    = 1'b0;
    unique case (state)
      S_IDLE:  if (start) nextState = (cfgCount == '0) ? S_DONE : S_FETCH;
      S_FETCH: nextState = S_LOAD;
      S_LOAD: begin
        ctl.load  = 1'b1;
        nextState = S_SIZE;
      end
      S_SIZE: begin
        if (remZero) nextState = S_NEXT;
        else begin
          ctl.size  = 1'b1;
          nextState = S_WAIT;
        end
      end
      S_WAIT:  if (room) nextState = S_HDR;
      S_HDR: begin
        pktValid = 1'b1;
        pktSop   = 1'b1;
        pktLast  = isRead;
        if (pktReady) begin
          ctl.advance = 1'b1;
          nextState   = isRead ? S_CPL : S_DATA;
        end
      end
      S_DATA: begin
        pktValid = 1'b1;
        selData  = 1'b1;
        pktLast  = lastBeat;
        txPop    = pktReady;
        if (pktReady && lastBeat) nextState = S_SIZE;
      end
      S_CPL: begin
        rxPush = cplValid;
        if (cplValid && lastBeat) nextState = S_SIZE;
      end
      S_NEXT:  nextState = lastDesc ? S_DONE : S_FETCH;
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      idx   <= '0;
      beat  <= '0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && start) idx <= '0;
      else if (state == S_NEXT && !lastDesc) idx <= idx + IDX_W'(1);
      if (state == S_HDR && pktReady) beat <= '0;
      else if ((state == S_DATA && pktReady) || (state == S_CPL && cplValid))
        beat <= beat + WORDS_W'(1);
    end
  end

  assign rdIdx = idx;
  assign busy  = (state != S_IDLE);
  assign irq   = (state == S_DONE);

  // R6: never pop from an empty transmit FIFO
  a_r6_tx_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> (txLevel != '0));
  // R7: never push into a full receive FIFO
  a_r7_rx_room: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> (rxFree != '0));
  // R8: interrupt is one cycle and ends the busy window
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> (!irq && !busy));
  // R10: a stalled beat stays offered
  a_r10_valid_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktReady) |=> (pktValid && $stable(pktSop) && $stable(pktLast)));
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
  import sgdma_pkg::*;
#(
  parameter int DESC_DEPTH = 1024,
  parameter int LEN_W      = 16,
  parameter int LVL_W      = 12,
  localparam int IDX_W     = $clog2(DESC_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              descWe,
  input  logic [IDX_W-1:0]  descWrIdx,
  input  logic [31:0]       descWrAddr,
  input  logic [LEN_W-1:0]  descWrLen,
  input  logic [IDX_W:0]    cfgCount,
  input  logic              cfgRead,
  input  logic [3:0]        cfgPayCode,
  input  logic [3:0]        cfgReadCode,
  input  logic              start,
  output logic              busy,
  output logic              irq,
  output logic              pktValid,
  input  logic              pktReady,
  output logic              pktSop,
  output logic              pktLast,
  output logic [63:0]       pktData,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [63:0]       txData,
  output logic              txPop,
  input  logic [LVL_W-1:0]  rxFree,
  input  logic              cplValid,
  input  logic [63:0]       cplData,
  output logic              rxPush,
  output logic [63:0]       rxData
);
  dpCtl_t             ctl;
  logic [IDX_W-1:0]   rdIdx;
  logic               remZero, selData;
  logic [WORDS_W-1:0] pktWords;
  logic [63:0]        hdrWord;

  sgdma_datapath #(.DESC_DEPTH(DESC_DEPTH), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .descWe(descWe), .descWrIdx(descWrIdx),
    .descWrAddr(descWrAddr), .descWrLen(descWrLen), .rdIdx(rdIdx), .ctl(ctl),
    .isRead(cfgRead), .payCode(cfgPayCode), .readCode(cfgReadCode),
    .remZero(remZero), .pktWords(pktWords), .hdrWord(hdrWord)
  );

  sgdma_ctrl #(.IDX_W(IDX_W), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgCount(cfgCount), .isRead(cfgRead),
    .txLevel(txLevel), .rxFree(rxFree), .pktReady(pktReady), .cplValid(cplValid),
    .remZero(remZero), .pktWords(pktWords), .ctl(ctl), .rdIdx(rdIdx),
    .pktValid(pktValid), .pktSop(pktSop), .pktLast(pktLast), .selData(selData),
    .txPop(txPop), .rxPush(rxPush), .busy(busy), .irq(irq)
  );

  assign pktData = selData ? txData : hdrWord;
  assign rxData  = cplData;

  // R3: write packet size within payload limit
  a_r3_pay_cap: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktSop && pktData[63]) |-> (pktData[44:32] <= capBytes(cfgPayCode)));
  // R4: read request size within request limit
  a_r4_req_cap: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktSop && !pktData[63]) |-> (pktData[44:32] <= capBytes(cfgReadCode)));
  // R5: no packet crosses a 4 KB boundary
  a_r5_no_cross: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktSop) |-> ((32'(pktData[11:0]) + 32'(pktData[47:32])) <= 32'(PAGE_BYTES)));
  // R10: stalled beat data is stable
  a_r10_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktReady) |=> $stable(pktData));
endmodule

// File: tb/sg_dma_engine_bench.sv
`timescale 1ns/1ps
module sg_dma_engine_bench;
  localparam int LVL_W = 12;
  localparam int NLOG  = 2048;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic descWe = 1'b0;
  logic [9:0] descWrIdx = '0;
  logic [31:0] descWrAddr = '0;
  logic [15:0] descWrLen = '0;
  logic [10:0] cfgCount = '0;
  logic cfgRead = 1'b0;
  logic [3:0] cfgPayCode = 4'd4, cfgReadCode = 4'd9;
  logic start = 1'b0;
  logic busy, irq, pktValid, pktSop, pktLast, txPop, rxPush;
  logic pktReady = 1'b1;
  logic [63:0] pktData, rxData;
  logic [LVL_W-1:0] txLevel;
  logic [63:0] txData;
  logic [LVL_W-1:0] rxFree = 12'd1024;
  logic cplValid = 1'b0;
  logic [63:0] cplData = '0;

  sg_dma_engine u_sg_dma_engine (
    .clk(clk), .rstN(rstN), .descWe(descWe), .descWrIdx(descWrIdx),
    .descWrAddr(descWrAddr), .descWrLen(descWrLen), .cfgCount(cfgCount),
    .cfgRead(cfgRead), .cfgPayCode(cfgPayCode), .cfgReadCode(cfgReadCode),
    .start(start), .busy(busy), .irq(irq), .pktValid(pktValid), .pktReady(pktReady),
    .pktSop(pktSop), .pktLast(pktLast), .pktData(pktData), .txLevel(txLevel),
    .txData(txData), .txPop(txPop), .rxFree(rxFree), .cplValid(cplValid),
    .cplData(cplData), .rxPush(rxPush), .rxData(rxData)
  );

  int tests = 0, fails = 0;
  int txHead = 0, txFill = 0;
  bit popPend = 0, bpEn = 0, doneFlag = 0;
  int cyc = 0;
  logic [63:0] beatD [NLOG];
  bit beatSop [NLOG];
  bit beatLast [NLOG];
  logic [63:0] rxLog [NLOG];
  logic [31:0] reqAddr [NLOG];
  int reqWords [NLOG];
  int nBeat = 0, nRx = 0, nReq = 0, irqCnt = 0, rp = 0, wp = 0;
  logic [31:0] dA [8];
  int dL [8];
  int nD = 0;

  assign txLevel = LVL_W'(txFill - txHead);
  assign txData  = {32'hDA7A0000, 32'(txHead)};

  // monitor: sample away from the rising edge
  always @(negedge clk) if (rstN) begin
    if (pktValid && pktReady && nBeat < NLOG) begin
      beatD[nBeat] = pktData; beatSop[nBeat] = pktSop; beatLast[nBeat] = pktLast;
      nBeat++;
      if (pktSop && !pktData[63]) begin
        reqAddr[nReq] = pktData[31:0]; reqWords[nReq] = int'(pktData[47:35]); nReq++;
      end
    end
    if (txPop) popPend = 1;
    if (rxPush && nRx < NLOG) begin rxLog[nRx] = rxData; nRx++; end
    if (irq) irqCnt++;
  end

  // FIFO head, back-pressure and completion source
  always @(posedge clk) begin
    #1;
    cyc++;
    if (popPend) begin txHead++; popPend = 0; end
    pktReady = bpEn ? (cyc % 3 != 0) : 1'b1;
    if (rstN && rp < nReq && (!bpEn || cyc[0])) begin
      cplValid = 1'b1;
      cplData  = {32'hC0C00000, reqAddr[rp] + 32'(8 * wp)};
      wp++;
      if (wp == reqWords[rp]) begin rp++; wp = 0; end
    end else cplValid = 1'b0;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic resetAll();
    @(posedge clk); #1;
    rstN = 1'b0; bpEn = 0;
    nBeat = 0; nRx = 0; nReq = 0; irqCnt = 0; rp = 0; wp = 0;
    txHead = 0; txFill = 2000; popPend = 0; rxFree = 12'd1024;
    cycles(3);
    rstN = 1'b1;
  endtask

  task automatic loadTable();
    for (int i = 0; i < nD; i++) begin
      @(posedge clk); #1;
      descWe = 1'b1; descWrIdx = 10'(i); descWrAddr = dA[i]; descWrLen = 16'(dL[i]);
    end
    @(posedge clk); #1;
    descWe = 1'b0;
    cfgCount = 11'(nD);
  endtask

  task automatic pulseStart();
    @(posedge clk); #1; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
  endtask

  task automatic waitIrq(input int n, input string req);
    int t = 0;
    while (irqCnt < n && t < 20000) begin @(posedge clk); t++; end
    cycles(2);
    check(irqCnt == n, req, "irq count", 64'(irqCnt), 64'(n));
    check(busy == 1'b0, "R8", "busy after irq", 64'(busy), 64'd0);
  endtask

  // rebuild expected packets from the table and compare
  task automatic checkRun(input int cap, input string req);
    int bi = 0, ri = 0, tw = 0, bad = 0;
    logic [63:0] firstAct = '0, firstExp = '0;
    for (int d = 0; d < nD; d++) begin
      int a = int'(dA[d]);
      int rem = dL[d];
      while (rem > 0) begin
        int sz = rem;
        logic [63:0] hdr;
        if (cap < sz) sz = cap;
        if (4096 - (a % 4096) < sz) sz = 4096 - (a % 4096);
        hdr = {~cfgRead, 15'd0, 16'(sz), 32'(a)};
        check(beatD[bi] == hdr && beatSop[bi] && (beatLast[bi] == cfgRead),
              "R5", "header", beatD[bi], hdr);
        bi++;
        for (int k = 0; k < sz / 8; k++) begin
          logic [63:0] ew;
          if (cfgRead) begin
            ew = {32'hC0C00000, 32'(a + 8 * k)};
            if (rxLog[ri] != ew) begin
              if (bad == 0) begin firstAct = rxLog[ri]; firstExp = ew; end
              bad++;
            end
            ri++;
          end else begin
            ew = {32'hDA7A0000, 32'(tw)};
            if (beatD[bi] != ew || beatSop[bi] || beatLast[bi] != (k == sz / 8 - 1)) begin
              if (bad == 0) begin firstAct = beatD[bi]; firstExp = ew; end
              bad++;
            end
            tw++; bi++;
          end
        end
        a += sz; rem -= sz;
      end
    end
    check(bad == 0, req, "payload words", firstAct, firstExp);
    check(nBeat == bi, req, "beat count", 64'(nBeat), 64'(bi));
    check(nRx == ri, req, "rx word count", 64'(nRx), 64'(ri));
  endtask

  task automatic testReset();
    resetAll();
    check(!busy && !irq && !pktValid && !txPop && !rxPush, "R1", "idle outputs",
          {59'd0, busy, irq, pktValid, txPop, rxPush}, 64'd0);
  endtask

  task automatic testWriteSplit();
    resetAll();
    cfgRead = 1'b0; cfgPayCode = 4'd4;
    nD = 3;
    dA[0] = 32'h1000; dL[0] = 512;
    dA[1] = 32'h2FC0; dL[1] = 192;
    dA[2] = 32'h5000; dL[2] = 136;
    loadTable();
    pulseStart();
    check(busy == 1'b1, "R8", "busy after start", 64'(busy), 64'd1);
    waitIrq(1, "R8");
    checkRun(128, "R3");
    check(txHead == 105, "R2", "words popped", 64'(txHead), 64'd105);
  endtask

  task automatic testWriteStall();
    resetAll();
    cfgRead = 1'b0; cfgPayCode = 4'd3; txFill = 0;
    nD = 1; dA[0] = 32'h8000; dL[0] = 64;
    loadTable();
    pulseStart();
    cycles(20);
    check(nBeat == 0, "R6", "no header with empty FIFO", 64'(nBeat), 64'd0);
    txFill = 7;
    cycles(20);
    check(nBeat == 0, "R6", "no header with partial FIFO", 64'(nBeat), 64'd0);
    txFill = 8;
    waitIrq(1, "R6");
    checkRun(64, "R6");
  endtask

  task automatic testRead();
    resetAll();
    cfgRead = 1'b1; cfgReadCode = 4'd9;
    nD = 2;
    dA[0] = 32'h10000; dL[0] = 8192;
    dA[1] = 32'h20F00; dL[1] = 512;
    loadTable();
    pulseStart();
    waitIrq(1, "R4");
    checkRun(4096, "R4");
    check(nReq == 4, "R4", "request count", 64'(nReq), 64'd4);
  endtask

  task automatic testReadStall();
    resetAll();
    cfgRead = 1'b1; cfgReadCode = 4'd9; rxFree = 12'd7;
    nD = 1; dA[0] = 32'h9000; dL[0] = 64;
    loadTable();
    pulseStart();
    cycles(20);
    check(nBeat == 0, "R7", "no request without room", 64'(nBeat), 64'd0);
    rxFree = 12'd8;
    waitIrq(1, "R7");
    checkRun(4096, "R7");
  endtask

  task automatic testBackPressure();
    resetAll();
    bpEn = 1;
    cfgRead = 1'b0; cfgPayCode = 4'd5;
    nD = 2; dA[0] = 32'h3F00; dL[0] = 400; dA[1] = 32'h7000; dL[1] = 72;
    loadTable();
    pulseStart();
    waitIrq(1, "R10");
    checkRun(256, "R10");
    resetAll();
    bpEn = 1;
    cfgRead = 1'b1; cfgReadCode = 4'd2;
    nD = 1; dA[0] = 32'hAFF0; dL[0] = 96;
    loadTable();
    pulseStart();
    waitIrq(1, "R10");
    checkRun(32, "R5");
  endtask

  task automatic testEdges();
    resetAll();
    cfgRead = 1'b0; cfgPayCode = 4'd4;
    nD = 0;
    cfgCount = '0;
    pulseStart();
    waitIrq(1, "R9");
    check(nBeat == 0, "R9", "no packets for empty list", 64'(nBeat), 64'd0);
    resetAll();
    nD = 2; dA[0] = 32'h100; dL[0] = 0; dA[1] = 32'h400; dL[1] = 16;
    loadTable();
    pulseStart();
    waitIrq(1, "R9");
    checkRun(128, "R9");
    resetAll();
    nD = 1; dA[0] = 32'h6000; dL[0] = 256;
    loadTable();
    pulseStart();
    cycles(5);
    check(busy == 1'b1, "R9", "busy mid run", 64'(busy), 64'd1);
    pulseStart();
    waitIrq(1, "R9");
    cycles(30);
    check(irqCnt == 1, "R9", "no second run", 64'(irqCnt), 64'd1);
    checkRun(128, "R9");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!doneFlag) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    testReset();
    testWriteSplit();
    testWriteStall();
    testRead();
    testReadStall();
    testBackPressure();
    testEdges();
    doneFlag = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule